// File: doc/BRIEF.md
# Parallel I/O Port Group with Global Output Release

The block gives software three byte-wide parallel ports (A, B and C) behind a small byte register bus. Port C is split into two nibble groups, so four direction groups exist, each set by one bit of a shared control byte. A fifth control bit holds every output driver in high impedance until software clears it. This lets software set directions and preload port data while nothing drives the pins, then release all drivers with one write.

Each pin has three signals: an output level, an output enable for an external pad buffer and an input level. Writes are synchronous and take effect on the clock edge where `wr_i` is high. Reads are combinational from `addr_i`. Only plain input and output are supported. Control writes that request any other mode are discarded.

Top module: `pio_ports`

## Requirements
- R1: After reset every output enable is low, every port data register is 0, and reading the control register (offset 3) returns 0x9B, which means all groups are inputs and the tristate flag is set.
- R2: The direction bits of the control byte are: bit 4 for port A, bit 1 for port B, bit 0 for port C bits 0..3 and bit 3 for port C bits 4..7. A value of 1 means input and 0 means output. The output enables of a group are high only when its bit is 0 and the tristate flag is clear.
- R3: While control bit 7 (the tristate flag) is 1, all output enables are low, whatever the direction bits say.
- R4: Writes to a port data register are accepted while the flag is set, and the port's pin outputs follow the register at all times. Once a control write clears bit 7, the preloaded value is driven on the output groups.
- R5: Port data writes never change the output enables. Enabled drivers stay enabled until a control write sets bit 7.
- R6: A control write with any of bits 2, 5 or 6 set is discarded. The control register and all output enables keep their previous values.
- R7: A port read returns the pin input for bits in input groups and the latched data for bits in output groups. The choice is made per nibble on port C.
- R8: Port A sits at offset 0, port B at offset 1, port C at offset 2 and the control register at offset 3. The control register reads back the last accepted control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A pin outputs |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B pin outputs |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C pin outputs |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
The hardest case to reach is a group whose direction is output but whose drivers are still held off, while its data register holds a nonzero value. The stimulus gets there by writing a control byte with bit 7 set and all groups set to output, then preloading distinct values into all three ports. It checks that the pin outputs already carry those values while the enables stay low. It then releases the drivers with a second control write and checks that the preloaded values appear unchanged. Mixed nibble directions on port C are read with pin patterns that differ from the latched data, so each nibble's source can be seen in the read value.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam logic [1:0] OFS_A    = 2'd0;
  localparam logic [1:0] OFS_B    = 2'd1;
  localparam logic [1:0] OFS_C    = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

  localparam int CB_TRI    = 7;
  localparam int CB_DIR_A  = 4;
  localparam int CB_DIR_CH = 3;
  localparam int CB_DIR_B  = 1;
  localparam int CB_DIR_CL = 0;

  localparam logic [7:0] CB_MODE_MASK = 8'h64;
  localparam logic [7:0] CB_RESET     = 8'h9B;

  typedef struct packed {
    logic tri_all;
    logic in_a;
    logic in_b;
    logic in_cl;
    logic in_ch;
  } pio_cfg_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o,
  output pio_cfg_t     cfg_o
);
  logic [W-1:0] ctrl_q;
  logic         mode_ok;

  assign mode_ok = ((wdata_i[7:0] & CB_MODE_MASK) == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= W'(CB_RESET);
    end else if (wr_i && mode_ok) begin
      ctrl_q <= wdata_i;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign cfg_o.tri_all = ctrl_q[CB_TRI];
  assign cfg_o.in_a    = ctrl_q[CB_DIR_A];
  assign cfg_o.in_b    = ctrl_q[CB_DIR_B];
  assign cfg_o.in_cl   = ctrl_q[CB_DIR_CL];
  assign cfg_o.in_ch   = ctrl_q[CB_DIR_CH];
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] dir_in_i,
  input  logic         tri_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (wr_i) begin
      data_q <= wdata_i;
    end
  end

  assign pin_o    = data_q;
  assign pin_oe_o = ~dir_in_i & {W{~tri_i}};
  assign rd_o     = (dir_in_i & pin_i) | (~dir_in_i & data_q);
endmodule

// File: rtl/pio_ports.sv
module pio_ports
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wr_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pa_i,
  output logic [W-1:0] pa_o,
  output logic [W-1:0] pa_oe_o,
  input  logic [W-1:0] pb_i,
  output logic [W-1:0] pb_o,
  output logic [W-1:0] pb_oe_o,
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] pc_oe_o
);
  localparam int NPORT = 3;
  localparam int HALF  = W / 2;

  logic [W-1:0] ctrl;
  pio_cfg_t     cfg;
  logic [W-1:0] dir_in [NPORT];
  logic [W-1:0] pin_in [NPORT];
  logic [W-1:0] pin_out[NPORT];
  logic [W-1:0] pin_oe [NPORT];
  logic [W-1:0] rd     [NPORT];

  pio_ctrl #(.W(W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i && (addr_i == OFS_CTRL)),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl),
    .cfg_o  (cfg)
  );

  assign dir_in[0] = {W{cfg.in_a}};
  assign dir_in[1] = {W{cfg.in_b}};
  assign dir_in[2] = {{(W-HALF){cfg.in_ch}}, {HALF{cfg.in_cl}}};

  assign pin_in[0] = pa_i;
  assign pin_in[1] = pb_i;
  assign pin_in[2] = pc_i;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    pio_port #(.W(W)) i_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i && (addr_i == 2'(g))),
      .wdata_i (wdata_i),
      .dir_in_i(dir_in[g]),
      .tri_i   (cfg.tri_all),
      .pin_i   (pin_in[g]),
      .pin_o   (pin_out[g]),
      .pin_oe_o(pin_oe[g]),
      .rd_o    (rd[g])
    );
  end

  assign pa_o    = pin_out[0];
  assign pb_o    = pin_out[1];
  assign pc_o    = pin_out[2];
  assign pa_oe_o = pin_oe[0];
  assign pb_oe_o = pin_oe[1];
  assign pc_oe_o = pin_oe[2];

  always_comb begin
    unique case (addr_i)
      OFS_A:   rdata_o = rd[0];
      OFS_B:   rdata_o = rd[1];
      OFS_C:   rdata_o = rd[2];
      default: rdata_o = ctrl;
    endcase
  end
endmodule

// File: rtl/pio_ports_chk.sv
module pio_ports_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic         wr_i,
  input logic [W-1:0] pa_o,
  input logic [W-1:0] pa_oe_o,
  input logic [W-1:0] pb_oe_o,
  input logic [W-1:0] pc_oe_o
);
  logic ctl_wr, bad_mode;
  assign ctl_wr   = wr_i && (addr_i == 2'd3);
  assign bad_mode = (wdata_i[6] || wdata_i[5] || wdata_i[2]);

  AST_TRI_BLOCKS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !bad_mode && wdata_i[7]) |=> (pa_oe_o == '0 && pb_oe_o == '0 && pc_oe_o == '0)); // R3

  AST_A_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !bad_mode && !wdata_i[7] && !wdata_i[4]) |=> (pa_oe_o == '1)); // R2

  AST_BAD_MODE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && bad_mode) |=> ($stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o))); // R6

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr |=> ($stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o))); // R5

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd0) |=> (pa_o == $past(wdata_i))); // R4
endmodule

bind pio_ports pio_ports_chk #(.W(W)) i_chk (.*);

// File: tb/test_pio_ports.sv
module test_pio_ports;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] rdata_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pb_o, pc_o, pa_oe_o, pb_oe_o, pc_oe_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pio_ports i_pio_ports (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic chk_oe(string req, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    chk({req, " oe A"}, pa_oe_o, a);
    chk({req, " oe B"}, pb_oe_o, b);
    chk({req, " oe C"}, pc_oe_o, c);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk_oe("R1", 8'h00, 8'h00, 8'h00);
    chk("R1 data A", pa_o, 8'h00);
    chk("R1 data C", pc_o, 8'h00);
    rd(2'd3, d);
    chk("R1 ctrl reset", d, 8'h9B);
  endtask

  task automatic t_preload;
    logic [7:0] d;
    wr(2'd3, 8'h80);
    chk_oe("R3", 8'h00, 8'h00, 8'h00);
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hC3);
    wr(2'd2, 8'h7E);
    chk("R4 preload A", pa_o, 8'h5A);
    chk("R4 preload B", pb_o, 8'hC3);
    chk("R4 preload C", pc_o, 8'h7E);
    chk_oe("R4 still tri", 8'h00, 8'h00, 8'h00);
    wr(2'd3, 8'h00);
    chk_oe("R4 release", 8'hFF, 8'hFF, 8'hFF);
    chk("R4 driven A", pa_o, 8'h5A);
    pa_i = 8'h0F; pb_i = 8'hF0; pc_i = 8'hA5;
    rd(2'd0, d); chk("R7 out A", d, 8'h5A);
    rd(2'd1, d); chk("R8 B offset", d, 8'hC3);
    rd(2'd2, d); chk("R8 C offset", d, 8'h7E);
  endtask

  task automatic t_dir;
    logic [7:0] d;
    wr(2'd3, 8'h10);
    chk_oe("R2 A in", 8'h00, 8'hFF, 8'hFF);
    rd(2'd0, d); chk("R7 in A", d, 8'h0F);
    wr(2'd3, 8'h02);
    chk_oe("R2 B in", 8'hFF, 8'h00, 8'hFF);
    rd(2'd1, d); chk("R7 in B", d, 8'hF0);
    wr(2'd3, 8'h01);
    chk_oe("R2 CL in", 8'hFF, 8'hFF, 8'hF0);
    rd(2'd2, d); chk("R7 C lo in", d, 8'h75);
    wr(2'd3, 8'h08);
    chk_oe("R2 CH in", 8'hFF, 8'hFF, 8'h0F);
    rd(2'd2, d); chk("R7 C hi in", d, 8'hAE);
    wr(2'd3, 8'h89);
    chk_oe("R3 tri mixed", 8'h00, 8'h00, 8'h00);
    rd(2'd3, d); chk("R8 ctrl readback", d, 8'h89);
  endtask

  task automatic t_hold;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h22);
    chk_oe("R5 data write", 8'hFF, 8'hFF, 8'hFF);
    chk("R5 new data", pa_o, 8'h11);
    wr(2'd3, 8'h80);
    chk_oe("R5 retri", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_badmode;
    logic [7:0] d;
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h04);
    chk_oe("R6 bit2", 8'hFF, 8'hFF, 8'hFF);
    wr(2'd3, 8'hA0);
    chk_oe("R6 bit5", 8'hFF, 8'hFF, 8'hFF);
    wr(2'd3, 8'h5B);
    chk_oe("R6 bit6", 8'hFF, 8'hFF, 8'hFF);
    rd(2'd3, d); chk("R6 ctrl kept", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_preload();
    t_dir();
    t_hold();
    t_badmode();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule